// File: doc/BRIEF.md
# JTAG User Register Bridge

This block sits behind a user data-register instruction of a JTAG test access port and gives a host access to a small bank of 32-bit registers. The TAP controller is represented by three single-cycle strobes (capture, shift, update) plus the serial data lines. The strobes are synchronous to the block clock. The host shifts a frame in least significant bit first and commits it with an update strobe. A 38-bit frame carrying a set write flag writes one register. A 6-bit frame with the write flag clear selects a register for reading. The selected value is loaded at the next capture and leaves on `tdo_o` during the following shift, least significant bit first.

The bank holds eight state words, three message words and a clock-frequency word. A write to the last message word starts a job. A sixteen-entry queue collects result nonces from the core. Reading the queue address pops its head, and an empty queue reads as all ones. Each frame is protected by odd parity. Any frame with bad parity, an unexpected length or a write flag that does not match its length is dropped without effect.

Top module: `jtag_reg_bridge`

## Requirements
- R1: A write frame is 38 bits shifted least significant bit first. Bits 31:0 carry the data, bits 35:32 the address, bit 36 the write flag (1) and bit 37 parity. After its update strobe the addressed register holds the data.
- R2: Parity is odd: the number of ones in the whole frame, parity bit included, must be odd. A frame failing this changes no register, no queue and no pending read data.
- R3: A read request is 6 bits: address in bits 3:0, write flag 0 in bit 4, parity in bit 5. Frames of any other length, and 6-bit frames with the flag set, are ignored.
- R4: The capture strobe loads the value selected by the last accepted read request, and `tdo_o` shows its bit 0 right after that capture. Each following shift strobe presents the next bit.
- R5: Addresses 1 to 8 are state words and 9 to 11 message words, seen on `work_words_o[a-1]`. Writes to 0, 12, 14 and 15 are ignored. Reads of 0, 12 and 15 return zero.
- R6: Address 13 holds the target clock frequency in MHz on `freq_mhz_o`. It can be read back.
- R7: Reading address 14 pops the head of the result queue and returns it. An empty queue returns 0xFFFFFFFF and stays empty.
- R8: The queue keeps 16 entries in arrival order. A push arriving while it is full is dropped and sets `nonce_ovf_o`, which stays set until reset.
- R9: An accepted write to address 11 raises `job_start_o` for exactly one cycle, in the same cycle the new value appears. No other write does.
- R10: After reset all registers, `freq_mhz_o`, `tdo_o`, `job_start_o` and `nonce_ovf_o` are zero and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_capture_i | input | 1 | Capture strobe: loads read data, restarts the bit count |
| tap_shift_i | input | 1 | Shift strobe: takes one bit from `tdi_i` |
| tap_update_i | input | 1 | Update strobe: decodes the shifted frame |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| nonce_valid_i | input | 1 | Result push request from the core |
| nonce_i | input | 32 | Result value to push |
| work_words_o | output | 352 | Eleven 32-bit state and message words, index a-1 for address a |
| freq_mhz_o | output | 32 | Target clock frequency word |
| job_start_o | output | 1 | One-cycle job start pulse |
| nonce_ovf_o | output | 1 | Sticky result queue overflow flag |

## Verification
The assertions assume that at most one TAP strobe is high in any cycle and that each update is a single-cycle pulse. The job-pulse check and the frame accounting depend on both. The bench drives every strobe from one task, one cycle at a time, so these conditions always hold. Result pushes are issued only between frames and never in the same cycle as a pop.

// File: rtl/jrb_pkg.sv
package jrb_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 4;
  localparam int WR_LEN      = DATA_W + ADDR_W + 2;
  localparam int RD_LEN      = ADDR_W + 2;
  localparam int CNT_W       = 6;
  localparam int NUM_STATE   = 8;
  localparam int NUM_MSG     = 3;
  localparam int NUM_WORK    = NUM_STATE + NUM_MSG;
  localparam int ADDR_JOB    = NUM_WORK;
  localparam int ADDR_FREQ   = 13;
  localparam int ADDR_POP    = 14;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } req_t;
endpackage

// File: rtl/jrb_shifter.sv
module jrb_shifter
  import jrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [DATA_W-1:0] load_i,
  output logic [WR_LEN-1:0] sr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tdo_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WR_LEN-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              sr_en;

  always_comb begin
    sr_en = capture_i | shift_i;
    sr_n  = sr_q;
    cnt_n = cnt_q;
    if (capture_i) begin
      sr_n  = {{(WR_LEN-DATA_W){1'b0}}, load_i};
      cnt_n = '0;
    end else if (shift_i) begin
      sr_n  = {tdi_i, sr_q[WR_LEN-1:1]};
      cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (sr_en) begin
      sr_q  <= sr_n;
      cnt_q <= cnt_n;
    end
  end

  assign sr_o  = sr_q;
  assign cnt_o = cnt_q;
  assign tdo_o = sr_q[0];

  // R4
  tap_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({capture_i, shift_i, update_i}));
endmodule

// File: rtl/jrb_decode.sv
module jrb_decode
  import jrb_pkg::*;
(
  input  logic              update_i,
  input  logic [WR_LEN-1:0] sr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output req_t              req_o
);
  localparam int FLAG_BIT = DATA_W + ADDR_W;
  localparam int RD_LSB   = WR_LEN - RD_LEN;

  logic              len_wr, len_rd, par_wr, par_rd;
  logic [RD_LEN-1:0] rd_frame;

  always_comb begin
    rd_frame = sr_i[WR_LEN-1:RD_LSB];
    len_wr   = (cnt_i == CNT_W'(WR_LEN));
    len_rd   = (cnt_i == CNT_W'(RD_LEN));
    par_wr   = ^sr_i;
    par_rd   = ^rd_frame;
    req_o    = '0;
    if (update_i && len_wr && par_wr && sr_i[FLAG_BIT]) begin
      req_o.wr   = 1'b1;
      req_o.addr = sr_i[FLAG_BIT-1:DATA_W];
      req_o.data = sr_i[DATA_W-1:0];
    end else if (update_i && len_rd && par_rd && !rd_frame[ADDR_W]) begin
      req_o.rd   = 1'b1;
      req_o.addr = rd_frame[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/jrb_fifo.sv
module jrb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ovf_q, ovf_n, full, do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    do_push = push_i && !full;
    do_pop  = pop_i && (cnt_q != '0);
    wp_n    = do_push ? ((wp_q == PTR_LAST) ? '0 : wp_q + 1'b1) : wp_q;
    rp_n    = do_pop  ? ((rp_q == PTR_LAST) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_n   = cnt_q;
    if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
    ovf_n   = ovf_q | (push_i && full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  assign head_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign ovf_o   = ovf_q;

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/jrb_regfile.sv
module jrb_regfile
  import jrb_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  req_t                             req_i,
  input  logic [DATA_W-1:0]                head_i,
  input  logic                             empty_i,
  output logic                             pop_o,
  output logic [DATA_W-1:0]                rd_data_o,
  output logic [NUM_WORK-1:0][DATA_W-1:0]  work_o,
  output logic [DATA_W-1:0]                freq_o,
  output logic                             job_o
);
  logic [NUM_WORK-1:0][DATA_W-1:0] work_q;
  logic [NUM_WORK-1:0]             work_we;
  logic [DATA_W-1:0]               freq_q, rd_q, rd_n;
  logic                            freq_we, rd_en, job_q, job_n;

  always_comb begin
    for (int i = 0; i < NUM_WORK; i++)
      work_we[i] = req_i.wr && (req_i.addr == ADDR_W'(i + 1));
    freq_we = req_i.wr && (req_i.addr == ADDR_W'(ADDR_FREQ));
    job_n   = req_i.wr && (req_i.addr == ADDR_W'(ADDR_JOB));
    pop_o   = req_i.rd && (req_i.addr == ADDR_W'(ADDR_POP)) && !empty_i;
    rd_en   = req_i.rd;
    rd_n    = '0;
    for (int i = 0; i < NUM_WORK; i++)
      if (req_i.addr == ADDR_W'(i + 1)) rd_n = work_q[i];
    if (req_i.addr == ADDR_W'(ADDR_FREQ)) rd_n = freq_q;
    if (req_i.addr == ADDR_W'(ADDR_POP))  rd_n = empty_i ? '1 : head_i;
  end

  for (genvar g = 0; g < NUM_WORK; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          work_q[g] <= '0;
      else if (work_we[g]) work_q[g] <= req_i.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      rd_q   <= '0;
      job_q  <= 1'b0;
    end else begin
      if (freq_we) freq_q <= req_i.data;
      if (rd_en)   rd_q   <= rd_n;
      job_q <= job_n;
    end
  end

  assign work_o    = work_q;
  assign freq_o    = freq_q;
  assign rd_data_o = rd_q;
  assign job_o     = job_q;

  // R9
  job_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_o |=> !job_o);
  // R6
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i.wr && req_i.addr == ADDR_W'(ADDR_FREQ)) |=> $stable(freq_o));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i.rd |=> $stable(rd_data_o));
endmodule

// File: rtl/jtag_reg_bridge.sv
module jtag_reg_bridge
  import jrb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tap_capture_i,
  input  logic                            tap_shift_i,
  input  logic                            tap_update_i,
  input  logic                            tdi_i,
  output logic                            tdo_o,
  input  logic                            nonce_valid_i,
  input  logic [DATA_W-1:0]               nonce_i,
  output logic [NUM_WORK-1:0][DATA_W-1:0] work_words_o,
  output logic [DATA_W-1:0]               freq_mhz_o,
  output logic                            job_start_o,
  output logic                            nonce_ovf_o
);
  localparam int FIFO_DEPTH = 16;

  logic [WR_LEN-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_data, head;
  logic              empty, pop;
  req_t              req;

  jrb_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .capture_i(tap_capture_i), .shift_i(tap_shift_i),
    .update_i(tap_update_i), .tdi_i(tdi_i), .load_i(rd_data), .sr_o(sr),
    .cnt_o(cnt), .tdo_o(tdo_o));

  jrb_decode u_dec (
    .update_i(tap_update_i), .sr_i(sr), .cnt_i(cnt), .req_o(req));

  jrb_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .req_i(req), .head_i(head), .empty_i(empty),
    .pop_o(pop), .rd_data_o(rd_data), .work_o(work_words_o),
    .freq_o(freq_mhz_o), .job_o(job_start_o));

  jrb_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(nonce_valid_i), .data_i(nonce_i),
    .pop_i(pop), .head_o(head), .empty_o(empty), .ovf_o(nonce_ovf_o));
endmodule

// File: tb/tb_jtag_reg_bridge.sv
`timescale 1ns/1ps
module tb_jtag_reg_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap = 1'b0, sft = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic tdo, nv = 1'b0, job, ovf;
  logic [31:0] nonce = '0, freq;
  logic [10:0][31:0] words;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] obs_word;
  logic [31:0] model[11];
  event        word_ev;
  bit          job_seen;

  always #5 clk = ~clk;

  jtag_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .tap_capture_i(cap), .tap_shift_i(sft),
    .tap_update_i(upd), .tdi_i(tdi), .tdo_o(tdo), .nonce_valid_i(nv),
    .nonce_i(nonce), .work_words_o(words), .freq_mhz_o(freq),
    .job_start_o(job), .nonce_ovf_o(ovf));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(word_ev);
    if (exp_q.size() == 0) check("monitor-unexpected", obs_word, 32'hx);
    else check(tag_q.pop_front(), obs_word, exp_q.pop_front());
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(logic [63:0] bits, int n, bit do_upd);
    cap = 1'b1; tick(); cap = 1'b0;
    for (int i = 0; i < n; i++) begin
      sft = 1'b1; tdi = bits[i]; tick();
    end
    sft = 1'b0; tdi = 1'b0;
    job_seen = 1'b0;
    if (do_upd) begin
      upd = 1'b1; tick(); upd = 1'b0;
      job_seen = job;
    end
  endtask

  function automatic logic [63:0] wr_frame(logic [3:0] a, logic [31:0] d);
    logic [36:0] body = {1'b1, a, d};
    return {26'd0, ~^body, body};
  endfunction

  function automatic logic [63:0] rd_frame(logic [3:0] a);
    logic [4:0] body = {1'b0, a};
    return {58'd0, ~^body, body};
  endfunction

  task automatic collect();
    logic [31:0] w;
    cap = 1'b1; tick(); cap = 1'b0;
    w[0] = tdo;
    for (int i = 1; i < 32; i++) begin
      sft = 1'b1; tick(); w[i] = tdo;
    end
    sft = 1'b0;
    obs_word = w;
    ->word_ev;
    #1;
  endtask

  task automatic read_reg(logic [3:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    send(rd_frame(a), 6, 1'b1);
    collect();
  endtask

  task automatic write_reg(logic [3:0] a, logic [31:0] d);
    send(wr_frame(a, d), 38, 1'b1);
  endtask

  task automatic push(logic [31:0] v);
    nv = 1'b1; nonce = v; tick(); nv = 1'b0;
  endtask

  task automatic check_words(string tag);
    for (int i = 0; i < 11; i++) check(tag, words[i], model[i]);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 11; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R10 reset state
    check("R10 tdo", {31'd0, tdo}, 32'd0);
    check("R10 job", {31'd0, job}, 32'd0);
    check("R10 ovf", {31'd0, ovf}, 32'd0);
    check("R10 freq", freq, 32'd0);
    check_words("R10 words");

    // R1 R5 R9 writes to every work address
    for (int a = 1; a <= 11; a++) begin
      logic [31:0] v = 32'h1000_0000 * a + 32'h0135_79BD ^ (a << 7);
      write_reg(4'(a), v);
      model[a-1] = v;
      check((a == 11) ? "R9 job pulse" : "R9 no job pulse", {31'd0, job_seen}, {31'd0, a == 11});
      if (a == 11) begin tick(); check("R9 job one cycle", {31'd0, job}, 32'd0); end
    end
    check_words("R1 R5 written words");

    // R4 R5 read back
    read_reg(4'd1, model[0], "R4 read state1");
    read_reg(4'd8, model[7], "R5 read state8");
    read_reg(4'd9, model[8], "R5 read msg9");
    read_reg(4'd11, model[10], "R5 read msg11");

    // R6 frequency word
    write_reg(4'd13, 32'd400);
    check("R6 freq", freq, 32'd400);
    read_reg(4'd13, 32'd400, "R6 read freq");

    // R2 bad parity write and read
    send(wr_frame(4'd2, 32'hDEAD_BEEF) ^ (64'd1 << 37), 38, 1'b1);
    check_words("R2 bad parity write");
    read_reg(4'd3, model[2], "R2 setup read");
    send(rd_frame(4'd5) ^ (64'd1 << 5), 6, 1'b1);
    exp_q.push_back(model[2]); tag_q.push_back("R2 bad parity read ignored");
    collect();

    // R3 wrong length and flag mismatch
    send(wr_frame(4'd4, 32'hCAFE_0001), 37, 1'b1);
    send(wr_frame(4'd4, 32'hCAFE_0001), 39, 1'b1);
    check_words("R3 wrong length write");
    send({58'd0, ~^{1'b1, 4'd6}, 1'b1, 4'd6}, 6, 1'b1);
    exp_q.push_back(model[2]); tag_q.push_back("R3 flagged 6-bit frame ignored");
    collect();

    // R5 unmapped addresses
    write_reg(4'd0, 32'h5555_5555);
    write_reg(4'd12, 32'h6666_6666);
    write_reg(4'd15, 32'h7777_7777);
    check_words("R5 unmapped writes");
    check("R5 freq untouched", freq, 32'd400);
    read_reg(4'd0, 32'd0, "R5 read addr0");
    read_reg(4'd12, 32'd0, "R5 read addr12");

    // R7 empty pop and write to queue address
    read_reg(4'd14, 32'hFFFF_FFFF, "R7 empty pop");
    write_reg(4'd14, 32'h1234_5678);
    read_reg(4'd14, 32'hFFFF_FFFF, "R7 write to pop addr ignored");

    // R7 R8 order
    push(32'hA0); push(32'hA1); push(32'hA2);
    read_reg(4'd14, 32'hA0, "R8 order 0");
    read_reg(4'd14, 32'hA1, "R8 order 1");
    read_reg(4'd14, 32'hA2, "R8 order 2");
    read_reg(4'd14, 32'hFFFF_FFFF, "R7 drained");
    check("R8 no overflow yet", {31'd0, ovf}, 32'd0);

    // R8 overflow
    for (int i = 0; i < 18; i++) push(32'hB000 + i);
    check("R8 overflow set", {31'd0, ovf}, 32'd1);
    for (int i = 0; i < 16; i++) read_reg(4'd14, 32'hB000 + i, "R8 full contents");
    read_reg(4'd14, 32'hFFFF_FFFF, "R8 dropped pushes");
    check("R8 overflow sticky", {31'd0, ovf}, 32'd1);
    check_words("R5 words stable at end");

    repeat (4) tick();
    if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule